// File: doc/BRIEF.md
# Serial Register-File Slave with Burst Pointer

This block is the serial front end of a timekeeping device. A host selects it with an active-low chip select and shifts bytes in on a serial clock, most significant bit first. The first byte in each selection carries a direction flag and a register address. Every later byte in the same selection is data. After each data byte an internal pointer advances, so the host can move a run of registers in one burst.

Addresses up to 13h belong to the timekeeping and control logic. That logic sits outside the block and is reached through a write strobe and a combinational read port. Addresses 00h–06h hold the time. Reads of them return a snapshot held inside this block, so a multibyte read sees one coherent moment while the live counters keep running. Two more locations give indirect access to a 256-byte memory. One holds a memory address. The other is a data port: it keeps the pointer fixed on itself while the memory address steps on.

All pins are synchronised into a faster system clock. That clock must run at least eight times the serial clock rate.

Top module: `spi_regfile_slave`

## Requirements
- R1: Address byte format: bit 7 set means write and bit 7 clear means read. Bits 6:0 give the starting register address. The output is enabled for every data byte of a read from a non-reserved address.
- R2: Bits are taken on the trailing serial-clock edge and driven on the leading edge, MSB first, eight bits per byte. The idle level at the chip-select fall sets the clock polarity, and both polarities work.
- R3: During a read the pointer steps by one after each byte and goes from 13h back to 00h.
- R4: During a write the pointer steps the same way. A burst that starts at 93h writes register 13h and then register 00h.
- R5: Addresses 14h–17h and 1Ah–7Fh are reserved. A write there commits nothing. A read there leaves the output disabled. The pointer stays where it is.
- R6: The time bytes (00h–06h, byte n = bits 8n+7:8n of the live time input) are captured when chip select falls, and snap_stb pulses. Reads return the captured copy.
- R7: When a read burst wraps from 13h to 00h, the live time is captured again. The byte read at 00h and the bytes after it come from that new capture.
- R8: A data byte is committed only after its eighth bit. For addresses 00h–13h, one reg_we pulse carries the address and the byte.
- R9: Writing 18h loads the 8-bit memory address, and reading 18h returns it. Accessing 19h reads or writes the memory at that address. The pointer stays on 19h, and the memory address then steps by one, going from FFh to 00h. No reg_we is issued for 18h or 19h.
- R10: dout_oe is low after reset, while chip select is high, during the address byte, and during every byte of a write.
- R11: Raising chip select in the middle of a byte drops that byte without committing it. The next selection starts again with an address byte.
- R12: A committed write to address 00h gives one sec_wr_stb pulse, at the same time as its reg_we. Writes to other addresses give none.
- R13: Reads of 07h–13h return reg_rdata for the address the block presents on reg_raddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for dout |
| reg_raddr | output | 7 | Register address being fetched |
| reg_rdata | input | 8 | Register contents for reg_raddr, same cycle |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_waddr | output | 7 | Register write address |
| reg_wdata | output | 8 | Register write data |
| time_live | input | 56 | Live time bytes, byte n at bits 8n+7:8n |
| snap_stb | output | 1 | Pulse when the time snapshot is taken |
| sec_wr_stb | output | 1 | Pulse when the seconds register is written |

## Verification
The bench changes the live time after chip select falls. A design that read the live counters directly, or that failed to capture again on the 13h-to-00h wrap, would return the wrong time bytes. Bursts that cross 13h, both reading and writing, expose a pointer that runs on to 14h. Reserved addresses read over four bytes would show the output enable coming on if the pointer moved into 18h. A memory burst that starts at FEh checks three things: the address rollover, the pointer holding on the data port, and the absence of stray register strobes. An aborted half byte and random bursts in both clock polarities catch early commits and polarity mistakes.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  typedef logic [6:0] ptr_t;

  localparam ptr_t TIME_LAST = 7'h06;
  localparam ptr_t LAST_REG  = 7'h13;
  localparam ptr_t MADDR_REG = 7'h18;
  localparam ptr_t MDATA_REG = 7'h19;

  // Holes in the map: no response, pointer frozen
  function automatic logic is_reserved(ptr_t p);
    return ((p > LAST_REG) && (p < MADDR_REG)) || (p > MDATA_REG);
  endfunction

  // Pointer after one data byte
  function automatic ptr_t ptr_step(ptr_t p);
    if (is_reserved(p) || p == MDATA_REG) return p;
    if (p == LAST_REG) return '0;
    return p + 7'd1;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic cs_s,
  output logic din_s,
  output logic cs_fall,
  output logic lead,
  output logic trail
);
  localparam int W = 3 * STAGES;
  localparam logic [2:0] IDLE_V = 3'b010; // {sclk, cs_n, din}

  logic [W-1:0] pipe;
  logic [2:0]   synced;
  logic         sclk_s, prev_sclk, prev_cs, cpol;
  logic         sclk_chg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pipe <= {STAGES{IDLE_V}};
    else        pipe <= {pipe[W-4:0], sclk, cs_n, din};

  assign synced = pipe[W-1 -: 3];
  assign sclk_s = synced[2];
  assign cs_s   = synced[1];
  assign din_s  = synced[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_sclk <= 1'b0;
      prev_cs   <= 1'b1;
      cpol      <= 1'b0;
    end else begin
      prev_sclk <= sclk_s;
      prev_cs   <= cs_s;
      if (cs_fall) cpol <= sclk_s;
    end

  assign cs_fall  = prev_cs & ~cs_s;
  assign sclk_chg = (sclk_s ^ prev_sclk) & ~cs_s & ~prev_cs;
  assign lead     = sclk_chg & (sclk_s != cpol);
  assign trail    = sclk_chg & (sclk_s == cpol);

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead && trail)); // R2
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            lead,
  input  logic            trail,
  input  logic            din_s,
  input  logic            load,
  input  logic [BITS-1:0] load_byte,
  output logic            dout_bit,
  output logic            byte_done,
  output logic [BITS-1:0] rx_byte
);
  localparam int CNT_W = $clog2(BITS);

  logic [CNT_W-1:0] cnt;
  logic [BITS-1:0]  rx_sh, tx_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt       <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
      dout_bit  <= 1'b0;
    end else if (!active) begin
      cnt       <= '0;   // partial byte dropped
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (trail) begin
        rx_sh <= {rx_sh[BITS-2:0], din_s};
        cnt   <= cnt + 1'b1;
        if (cnt == CNT_W'(BITS - 1)) begin
          byte_done <= 1'b1;
          rx_byte   <= {rx_sh[BITS-2:0], din_s};
        end
      end
      if (load) tx_sh <= load_byte;
      else if (lead) begin
        dout_bit <= tx_sh[BITS-1];
        tx_sh    <= {tx_sh[BITS-2:0], 1'b0};
      end
    end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done); // R2
  AST_ABORT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0)); // R11
endmodule

// File: rtl/spi_time_snap.sv
module spi_time_snap #(
  parameter int TIME_BYTES = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    capture,
  input  logic [8*TIME_BYTES-1:0] live,
  output logic [8*TIME_BYTES-1:0] snap
);
  for (genvar g = 0; g < TIME_BYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       snap[8*g +: 8] <= '0;
      else if (capture) snap[8*g +: 8] <= live[8*g +: 8];
  end

  AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (snap == $past(live))); // R6
endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
  import spi_rf_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TIME_BYTES  = 7,
  parameter int MEM_DEPTH   = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sclk,
  input  logic                    cs_n,
  input  logic                    din,
  output logic                    dout,
  output logic                    dout_oe,
  output logic [6:0]              reg_raddr,
  input  logic [7:0]              reg_rdata,
  output logic                    reg_we,
  output logic [6:0]              reg_waddr,
  output logic [7:0]              reg_wdata,
  input  logic [8*TIME_BYTES-1:0] time_live,
  output logic                    snap_stb,
  output logic                    sec_wr_stb
);
  localparam int MEM_AW = $clog2(MEM_DEPTH);

  logic cs_s, din_s, cs_fall, lead, trail, cs_active;
  logic byte_done, tx_load;
  logic [7:0] rx_byte, load_byte;
  logic [8*TIME_BYTES-1:0] snap_q;

  logic in_data, is_wr;
  ptr_t ptr, nptr, la;
  logic [MEM_AW-1:0] maddr, lm;
  logic [7:0] mem [MEM_DEPTH];

  // Named events for control and assertions
  logic hdr_done, rd_adv, wr_commit, wrap_rd, use_live, mem_wr;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .cs_s(cs_s), .din_s(din_s), .cs_fall(cs_fall), .lead(lead), .trail(trail));

  assign cs_active = ~cs_s;

  spi_bit_engine #(.BITS(8)) u_bits (
    .clk(clk), .rst_n(rst_n), .active(cs_active), .lead(lead), .trail(trail),
    .din_s(din_s), .load(tx_load), .load_byte(load_byte),
    .dout_bit(dout), .byte_done(byte_done), .rx_byte(rx_byte));

  spi_time_snap #(.TIME_BYTES(TIME_BYTES)) u_snap (
    .clk(clk), .rst_n(rst_n), .capture(cs_fall | wrap_rd),
    .live(time_live), .snap(snap_q));

  assign hdr_done  = byte_done & cs_active & ~in_data;
  assign rd_adv    = byte_done & cs_active & in_data & ~is_wr;
  assign wr_commit = byte_done & cs_active & in_data & is_wr;
  assign wrap_rd   = rd_adv & (ptr == LAST_REG);
  assign nptr      = ptr_step(ptr);
  assign tx_load   = (hdr_done & ~rx_byte[7]) | rd_adv;
  assign mem_wr    = wr_commit & (ptr == MDATA_REG);

  // Address and memory address of the byte to preload
  always_comb begin
    la       = rx_byte[6:0];
    lm       = maddr;
    use_live = 1'b0;
    if (rd_adv) begin
      la       = nptr;
      lm       = (ptr == MDATA_REG) ? maddr + 1'b1 : maddr;
      use_live = wrap_rd;
    end
  end

  assign reg_raddr = la;

  always_comb begin
    load_byte = '0;
    if (la <= TIME_LAST)
      load_byte = use_live ? time_live[8*int'(la) +: 8] : snap_q[8*int'(la) +: 8];
    else if (la <= LAST_REG)  load_byte = reg_rdata;
    else if (la == MADDR_REG) load_byte = 8'(lm);
    else if (la == MDATA_REG) load_byte = mem[lm];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_data    <= 1'b0;
      is_wr      <= 1'b0;
      ptr        <= '0;
      maddr      <= '0;
      dout_oe    <= 1'b0;
      reg_we     <= 1'b0;
      reg_waddr  <= '0;
      reg_wdata  <= '0;
      sec_wr_stb <= 1'b0;
      snap_stb   <= 1'b0;
    end else begin
      reg_we     <= 1'b0;
      sec_wr_stb <= 1'b0;
      snap_stb   <= cs_fall | wrap_rd;
      if (!cs_active) begin
        in_data <= 1'b0;
        dout_oe <= 1'b0;
      end else if (hdr_done) begin
        in_data <= 1'b1;
        is_wr   <= rx_byte[7];
        ptr     <= rx_byte[6:0];
        dout_oe <= ~rx_byte[7] & ~is_reserved(rx_byte[6:0]);
      end else if (rd_adv) begin
        ptr     <= nptr;
        maddr   <= lm;
        dout_oe <= ~is_reserved(nptr);
      end else if (wr_commit) begin
        ptr <= nptr;
        if (ptr == MADDR_REG) maddr <= rx_byte[MEM_AW-1:0];
        else if (ptr == MDATA_REG) maddr <= maddr + 1'b1;
        else if (ptr <= LAST_REG) begin
          reg_we     <= 1'b1;
          reg_waddr  <= ptr;
          reg_wdata  <= rx_byte;
          sec_wr_stb <= (ptr == '0);
        end
      end
    end

  always_ff @(posedge clk)
    if (mem_wr) mem[maddr] <= rx_byte;

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !dout_oe); // R10
  AST_RD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_rd |=> (ptr == '0)); // R3
  AST_RSV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && cs_active && in_data && is_reserved(ptr)) |=> (ptr == $past(ptr))); // R5
  AST_MDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && cs_active && in_data && ptr == MDATA_REG) |=> (ptr == MDATA_REG)); // R9
  AST_SEC_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wr_stb |-> (reg_we && reg_waddr == '0)); // R12
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R8
  AST_SNAP_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> snap_stb); // R6
endmodule

// File: tb/tb_spi_regfile_slave.sv
module tb_spi_regfile_slave;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, sclk, cs_n, din;
  logic dout, dout_oe, reg_we, snap_stb, sec_wr_stb;
  logic [6:0] reg_raddr, reg_waddr;
  logic [7:0] reg_rdata, reg_wdata;
  logic [55:0] time_live;

  spi_regfile_slave dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout(dout), .dout_oe(dout_oe), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .time_live(time_live), .snap_stb(snap_stb), .sec_wr_stb(sec_wr_stb));

  // Register file model outside the block
  logic [7:0] ext [128];
  assign reg_rdata = ext[reg_raddr];

  int errors = 0, checks = 0, wcount = 0, sec_cnt = 0, snap_cnt = 0;
  logic [6:0] wlog_a [256];
  logic [7:0] wlog_d [256];
  logic [7:0] shadow [128];

  always @(posedge clk) if (rst_n) begin
    if (reg_we) begin
      ext[reg_waddr]       <= reg_wdata;
      wlog_a[wcount % 256] <= reg_waddr;
      wlog_d[wcount % 256] <= reg_wdata;
      wcount               <= wcount + 1;
    end
    if (sec_wr_stb) sec_cnt  <= sec_cnt + 1;
    if (snap_stb)   snap_cnt <= snap_cnt + 1;
  end

  logic cpol = 1'b0;
  logic oe_any, oe_all;
  logic [7:0] rxb;

  function automatic logic [6:0] bnext(input logic [6:0] a);
    return (a == 7'h13) ? 7'h00 : a + 7'd1;
  endfunction

  function automatic logic [7:0] tbyte(input logic [55:0] t, input int i);
    return t[8*i +: 8];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cs_begin(input logic pol);
    @(negedge clk);
    cpol = pol; sclk = pol;
    repeat (6) @(negedge clk);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_end;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int n);
    oe_any = 1'b0; oe_all = 1'b1;
    for (int i = 0; i < n; i++) begin
      sclk = ~cpol; din = tx[7-i];
      repeat (7) @(negedge clk);
      rxb[7-i] = dout;
      oe_any = oe_any | dout_oe;
      oe_all = oe_all & dout_oe;
      sclk = cpol;
      repeat (8) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx);
    xfer_bits(tx, 8);
  endtask

  logic [55:0] tl_a, tl_b, tl_c;
  int s0, w0;

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 128; i++) begin ext[i] = 8'h00; shadow[i] = 8'h00; end
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; din = 1'b0;
    tl_a = 56'h21_12_25_03_23_59_58;
    tl_b = 56'h21_12_25_03_23_59_59;
    tl_c = 56'h22_01_01_04_00_00_00;
    time_live = tl_a;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 reset oe", dout_oe, 0);
    chk("R8 reset we", reg_we, 0);

    // Snapshot at chip-select fall, live changes afterwards
    s0 = snap_cnt;
    cs_begin(1'b0);
    chk("R6 snap strobe", snap_cnt, s0 + 1);
    time_live = tl_b;
    xfer(8'h00);
    chk("R10 oe in header", oe_any, 0);
    for (int i = 0; i < 7; i++) begin
      xfer(8'hFF);
      chk("R6 snapshot byte", rxb, tbyte(tl_a, i));
      chk("R1 read oe", oe_all, 1);
    end
    cs_end;
    chk("R10 oe after cs high", dout_oe, 0);

    // Fill 07h..13h in polarity 1, then read back
    w0 = wcount;
    cs_begin(1'b1);
    xfer(8'h87);
    for (int a = 7; a <= 8'h13; a++) begin
      logic [7:0] d;
      d = 8'($urandom);
      xfer(d);
      shadow[a] = d;
      chk("R10 oe in write", oe_any, 0);
    end
    cs_end;
    chk("R8 write count", wcount, w0 + 13);
    for (int k = 0; k < 13; k++) begin
      chk("R8 write addr", wlog_a[(w0 + k) % 256], 7 + k);
      chk("R1 write data", wlog_d[(w0 + k) % 256], shadow[7 + k]);
    end
    cs_begin(1'b1);
    xfer(8'h07);
    for (int a = 7; a <= 8'h13; a++) begin
      xfer(8'h00);
      chk("R13 R2 readback", rxb, shadow[a]);
    end
    cs_end;

    // Read wrap 13h -> 00h takes a fresh snapshot
    s0 = snap_cnt;
    cs_begin(1'b0);
    time_live = tl_c;
    xfer(8'h12);
    xfer(8'h00); chk("R3 read 12h", rxb, shadow[8'h12]);
    xfer(8'h00); chk("R3 read 13h", rxb, shadow[8'h13]);
    xfer(8'h00); chk("R7 wrap byte0", rxb, tbyte(tl_c, 0));
    xfer(8'h00); chk("R7 wrap byte1", rxb, tbyte(tl_c, 1));
    cs_end;
    chk("R7 snap count", snap_cnt, s0 + 2);

    // Write wrap 93h -> 80h and seconds strobe
    w0 = wcount; s0 = sec_cnt;
    cs_begin(1'b1);
    xfer(8'h93); xfer(8'h5A); xfer(8'h33);
    cs_end;
    shadow[8'h13] = 8'h5A;
    chk("R4 wrap addr a", wlog_a[w0 % 256], 7'h13);
    chk("R4 wrap addr b", wlog_a[(w0 + 1) % 256], 7'h00);
    chk("R4 wrap data", wlog_d[(w0 + 1) % 256], 8'h33);
    chk("R12 seconds strobe", sec_cnt, s0 + 1);
    s0 = sec_cnt;
    cs_begin(1'b0); xfer(8'h81); xfer(8'h10); cs_end;
    chk("R12 no strobe for 01h", sec_cnt, s0);
    cs_begin(1'b0); xfer(8'h80); xfer(8'h45); cs_end;
    chk("R12 strobe for 00h", sec_cnt, s0 + 1);

    // Reserved addresses
    w0 = wcount;
    cs_begin(1'b0); xfer(8'h94); xfer(8'h55); xfer(8'h66); cs_end;
    chk("R5 reserved write", wcount, w0);
    cs_begin(1'b1);
    xfer(8'h15);
    for (int k = 0; k < 4; k++) begin
      xfer(8'h00);
      chk("R5 reserved read oe", oe_any, 0);
    end
    cs_end;

    // Memory through address and data port
    w0 = wcount;
    cs_begin(1'b0);
    xfer(8'h98); xfer(8'hFE); xfer(8'hA1); xfer(8'hB2); xfer(8'hC3);
    cs_end;
    chk("R9 no reg strobe", wcount, w0);
    cs_begin(1'b1); xfer(8'h98); xfer(8'hFE); cs_end;
    cs_begin(1'b1);
    xfer(8'h19);
    xfer(8'h00); chk("R9 mem FE", rxb, 8'hA1);
    xfer(8'h00); chk("R9 mem FF", rxb, 8'hB2);
    xfer(8'h00); chk("R9 mem 00 rollover", rxb, 8'hC3);
    cs_end;
    cs_begin(1'b0); xfer(8'h18); xfer(8'h00); cs_end;
    chk("R9 mem address after wrap", rxb, 8'h01);

    // Aborted partial byte
    w0 = wcount;
    cs_begin(1'b0); xfer(8'h88); xfer_bits(8'hC3, 4);
    cs_n = 1'b1; repeat (10) @(negedge clk);
    chk("R11 abort no commit", wcount, w0);
    cs_begin(1'b1); xfer_bits(8'h87, 5);
    cs_n = 1'b1; repeat (10) @(negedge clk);
    cs_begin(1'b0); xfer(8'h08); xfer(8'h00); cs_end;
    chk("R11 fresh header", rxb, shadow[8]);

    // Random bursts, both polarities
    time_live = tl_b;
    for (int it = 0; it < 20; it++) begin
      logic pol;
      logic [6:0] st, a;
      int len;
      pol = 1'($urandom);
      st  = 7'(7 + $urandom % 13);
      len = 1 + $urandom % 8;
      w0  = wcount;
      cs_begin(pol);
      xfer({1'b1, st});
      a = st;
      for (int k = 0; k < len; k++) begin
        logic [7:0] d;
        d = 8'($urandom);
        xfer(d);
        shadow[a] = d;
        a = bnext(a);
      end
      cs_end;
      a = st;
      for (int k = 0; k < len; k++) begin
        chk("R4 random write addr", wlog_a[(w0 + k) % 256], a);
        a = bnext(a);
      end
      cs_begin(pol);
      xfer({1'b0, st});
      a = st;
      for (int k = 0; k < len; k++) begin
        xfer(8'h00);
        if (a <= 7'h06) chk("R3 random time read", rxb, tbyte(tl_b, int'(a)));
        else            chk("R13 random read", rxb, shadow[a]);
        a = bnext(a);
      end
      cs_end;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule